// File: doc/BRIEF.md
# Hardware Genetic Algorithm Engine

This block evolves a population of fixed-length binary chromosomes entirely in hardware. After a start pulse it seeds an internal pseudo-random generator and fills the population with random chromosomes. It then evaluates every individual through a request/acknowledge handshake with an external fitness evaluator. The block does not know the fitness function or the problem encoding.

After each evaluation pass the engine builds the next generation in a second population bank. The fittest individuals are copied across unchanged. Every other slot is filled in pairs: two parents are picked by roulette-wheel selection with a coarse random threshold, mixed by single-point crossover, and then possibly mutated. This repeats for a programmed number of generations. After the final evaluation pass the engine pulses `done_o` and presents the best chromosome and its fitness.

Top module: `ga_engine`

## Requirements
- R1: After reset `busy_o`, `done_o` and `eval_req_o` are low. `eval_req_o` is never high while `busy_o` is low.
- R2: A `start_i` pulse while idle captures `seed_i` and `gens_i` and raises `busy_o` on the next cycle. A `start_i` pulse while busy has no effect on the run in progress.
- R3: Each evaluation holds `eval_req_o` high with a stable `eval_chrom_o` until a cycle with `eval_ack_i` high, and `eval_fit_i` is taken in that cycle. Every generation evaluates all POP slots in slot order, so a run of G extra generations makes POP*(G+1) evaluations.
- R4: One cycle after the last evaluation of the final generation, `done_o` is high for exactly one cycle and `busy_o` is low in that same cycle. `best_fit_o` is the highest fitness of the final generation. `best_chrom_o` is the chromosome that reported it, and on a tie the lowest slot wins.
- R5: Slots 0..ELITE-1 of each new generation hold the ELITE fittest chromosomes of the previous one, in descending fitness order, with ties going to the lower slot. The highest fitness per generation therefore never decreases.
- R6: Each parent is chosen with a 4-bit random r. The threshold is ((r+1)*total)>>4, where total is the sum of the generation's fitness values. The parent is the lowest slot whose running fitness sum reaches that threshold, so a zero total always selects slot 0.
- R7: Each child pair uses one cut c in 1..15. Child 1 takes bits below c from parent B and the remaining bits from parent A. Child 2 is the opposite mix. Pairs fill slots ELITE, ELITE+1, and so on in order.
- R8: Each child independently has exactly one bit flipped when an 8-bit random value is below MUT_RATE; otherwise it is left unchanged. MUT_RATE = 0 disables mutation.
- R9: The same seed always gives the same run, and different seeds give different populations. A zero seed is replaced by a non-zero state so the generator cannot stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a run (ignored while busy) |
| seed_i | input | 32 | Generator seed, captured at start |
| gens_i | input | GEN_W | Number of generations bred after the initial one |
| eval_req_o | output | 1 | Fitness request |
| eval_chrom_o | output | CHROM_W | Chromosome to evaluate |
| eval_ack_i | input | 1 | Evaluator response valid |
| eval_fit_i | input | FIT_W | Fitness of the requested chromosome |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| best_chrom_o | output | CHROM_W | Best chromosome of the final generation |
| best_fit_o | output | FIT_W | Its fitness |

## Verification
The bench uses two instances. The first has the default 16-bit chromosomes, 32 individuals, two elites and a mutation rate of 80. It covers the evaluation count, elitism and the final best result over several generations. On it, a fitness concentrated on one individual bounds every bred child to at most one flipped bit of that individual, which exposes the mutation rate.

The second instance has 8 individuals and mutation disabled. Children then follow selection and crossover exactly. A zero fitness total, fitness on a single slot, and fitness shared by two slots therefore give fully predictable slot contents and crossover mixes.

// File: rtl/ga_pkg.sv
package ga_pkg;
  typedef enum logic [2:0] {
    GA_IDLE, GA_INIT, GA_EVAL, GA_FIN, GA_ELITE, GA_PREP, GA_SCAN, GA_WRITE
  } ga_st_e;
endpackage

// File: rtl/ga_lfsr.sv
module ga_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= W'(1);
    else if (load_i) st_q <= (seed_i == '0) ? W'(1) : seed_i;
    else             st_q <= {1'b0, st_q[W-1:1]} ^ (st_q[0] ? TAPS : '0);
  end

  assign rnd_o = st_q;
endmodule

// File: rtl/ga_xover.sv
module ga_xover #(
  parameter int W     = 16,
  parameter int CUT_W = $clog2(W)
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [CUT_W-1:0] cut_i,
  input  logic             mut_a_i,
  input  logic [CUT_W-1:0] bit_a_i,
  input  logic             mut_b_i,
  input  logic [CUT_W-1:0] bit_b_i,
  output logic [W-1:0]     c1_o,
  output logic [W-1:0]     c2_o
);
  logic [W-1:0] hi_mask, flip_a, flip_b;

  always_comb begin
    hi_mask = {W{1'b1}} << cut_i;
    flip_a  = mut_a_i ? (W'(1) << bit_a_i) : '0;
    flip_b  = mut_b_i ? (W'(1) << bit_b_i) : '0;
    c1_o = ((a_i & hi_mask) | (b_i & ~hi_mask)) ^ flip_a;
    c2_o = ((b_i & hi_mask) | (a_i & ~hi_mask)) ^ flip_b;
  end
endmodule

// File: rtl/ga_elite.sv
module ga_elite #(
  parameter int N     = 2,
  parameter int FIT_W = 16,
  parameter int IDX_W = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       upd_i,
  input  logic [FIT_W-1:0]           fit_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [N-1:0][IDX_W-1:0]    idx_o,
  output logic [N-1:0][FIT_W-1:0]    fit_o
);
  logic [N-1:0]              vld_q, vld_d;
  logic [N-1:0][FIT_W-1:0]   fit_q, fit_d;
  logic [N-1:0][IDX_W-1:0]   idx_q, idx_d;
  int                        pos;

  // sorted insert, strict compare keeps the earlier slot on ties
  always_comb begin
    pos = N;
    for (int k = N - 1; k >= 0; k--)
      if (!vld_q[k] || fit_i > fit_q[k]) pos = k;
    vld_d = vld_q;
    fit_d = fit_q;
    idx_d = idx_q;
    for (int k = 1; k < N; k++)
      if (k > pos) begin
        vld_d[k] = vld_q[k-1];
        fit_d[k] = fit_q[k-1];
        idx_d[k] = idx_q[k-1];
      end
    for (int k = 0; k < N; k++)
      if (k == pos) begin
        vld_d[k] = 1'b1;
        fit_d[k] = fit_i;
        idx_d[k] = idx_i;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      fit_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (upd_i) begin
      vld_q <= vld_d;
      fit_q <= fit_d;
      idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;
  assign fit_o = fit_q;
endmodule

// File: rtl/ga_engine.sv
module ga_engine
  import ga_pkg::*;
#(
  parameter int CHROM_W  = 16,
  parameter int FIT_W    = 16,
  parameter int POP      = 32,
  parameter int RND_W    = 4,
  parameter int ELITE    = 2,
  parameter int MUT_RATE = 80,
  parameter int GEN_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [31:0]        seed_i,
  input  logic [GEN_W-1:0]   gens_i,
  output logic               eval_req_o,
  output logic [CHROM_W-1:0] eval_chrom_o,
  input  logic               eval_ack_i,
  input  logic [FIT_W-1:0]   eval_fit_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CHROM_W-1:0] best_chrom_o,
  output logic [FIT_W-1:0]   best_fit_o
);
  localparam int IDX_W = $clog2(POP);
  localparam int CNT_W = IDX_W + 1;
  localparam int TOT_W = FIT_W + IDX_W;
  localparam int PRD_W = TOT_W + RND_W + 1;
  localparam int CUT_W = $clog2(CHROM_W);
  localparam int LF_W  = 32;

  ga_st_e                  st_q;
  logic                    bank_q, sel_b_q, done_q;
  logic [CNT_W-1:0]        idx_q;
  logic [IDX_W-1:0]        idx_lo, sidx_q, par_a_q, par_b_q, el_sel;
  logic [GEN_W-1:0]        gen_q, gens_q;
  logic [TOT_W-1:0]        tot_q, cum_q, thr_q, cum_n, thr_d;
  logic [PRD_W-1:0]        prod;
  logic [CHROM_W-1:0]      best_chrom_q, c1, c2;
  logic [FIT_W-1:0]        best_fit_q;
  logic [LF_W-1:0]         rnd;
  logic                    acc, hit, mut_a, mut_b;
  logic [CUT_W-1:0]        cut, bit_a, bit_b;
  logic [ELITE-1:0][IDX_W-1:0] el_idx;
  logic [ELITE-1:0][FIT_W-1:0] el_fit;

  logic [CHROM_W-1:0] pop_q [2][POP];
  logic [FIT_W-1:0]   fit_q [POP];

  assign idx_lo = idx_q[IDX_W-1:0];
  assign acc    = (st_q == GA_EVAL) && eval_ack_i;

  ga_lfsr #(.W(LF_W)) u_lfsr (
    .clk_i, .rst_ni,
    .load_i (st_q == GA_IDLE && start_i),
    .seed_i (seed_i),
    .rnd_o  (rnd)
  );

  ga_elite #(.N(ELITE), .FIT_W(FIT_W), .IDX_W(IDX_W)) u_elite (
    .clk_i, .rst_ni,
    .clr_i (st_q == GA_INIT || st_q == GA_WRITE),
    .upd_i (acc),
    .fit_i (eval_fit_i),
    .idx_i (idx_lo),
    .idx_o (el_idx),
    .fit_o (el_fit)
  );

  // random fields for one child pair
  always_comb begin
    mut_a = {1'b0, rnd[7:0]}  < 9'(MUT_RATE);
    mut_b = {1'b0, rnd[15:8]} < 9'(MUT_RATE);
    bit_a = CUT_W'(32'(rnd[16 +: CUT_W]) % CHROM_W);
    bit_b = CUT_W'(32'(rnd[20 +: CUT_W]) % CHROM_W);
    cut   = CUT_W'(32'(rnd[24 +: CUT_W]) % (CHROM_W - 1) + 1);
  end

  ga_xover #(.W(CHROM_W), .CUT_W(CUT_W)) u_xover (
    .a_i (pop_q[bank_q][par_a_q]), .b_i (pop_q[bank_q][par_b_q]),
    .cut_i (cut),
    .mut_a_i (mut_a), .bit_a_i (bit_a),
    .mut_b_i (mut_b), .bit_b_i (bit_b),
    .c1_o (c1), .c2_o (c2)
  );

  always_comb begin
    el_sel = el_idx[0];
    for (int k = 0; k < ELITE; k++)
      if (idx_q == CNT_W'(k)) el_sel = el_idx[k];
    prod  = (PRD_W'(rnd[RND_W-1:0]) + PRD_W'(1)) * PRD_W'(tot_q);
    thr_d = TOT_W'(prod >> RND_W);
    cum_n = cum_q + TOT_W'(fit_q[sidx_q]);
    hit   = (cum_n >= thr_q) || (sidx_q == IDX_W'(POP - 1));
  end

  always_ff @(posedge clk_i) begin
    if (st_q == GA_INIT) pop_q[bank_q][idx_lo] <= rnd[CHROM_W-1:0];
    if (st_q == GA_ELITE) pop_q[~bank_q][idx_lo] <= pop_q[bank_q][el_sel];
    if (st_q == GA_WRITE) begin
      pop_q[~bank_q][idx_lo] <= c1;
      if (32'(idx_q) + 1 < POP) pop_q[~bank_q][idx_lo + IDX_W'(1)] <= c2;
    end
    if (acc) fit_q[idx_lo] <= eval_fit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= GA_IDLE; bank_q <= 1'b0; sel_b_q <= 1'b0; done_q <= 1'b0;
      idx_q <= '0; sidx_q <= '0; par_a_q <= '0; par_b_q <= '0;
      gen_q <= '0; gens_q <= '0; tot_q <= '0; cum_q <= '0; thr_q <= '0;
      best_chrom_q <= '0; best_fit_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        GA_IDLE: if (start_i) begin
          idx_q <= '0; gen_q <= '0; gens_q <= gens_i; st_q <= GA_INIT;
        end
        GA_INIT: if (idx_q == CNT_W'(POP - 1)) begin
          idx_q <= '0; tot_q <= '0; st_q <= GA_EVAL;
        end else idx_q <= idx_q + 1'b1;
        GA_EVAL: if (eval_ack_i) begin
          tot_q <= tot_q + TOT_W'(eval_fit_i);
          if (idx_q == CNT_W'(POP - 1)) begin
            idx_q <= '0;
            st_q  <= (gen_q == gens_q) ? GA_FIN : GA_ELITE;
          end else idx_q <= idx_q + 1'b1;
        end
        GA_FIN: begin
          done_q       <= 1'b1;
          best_chrom_q <= pop_q[bank_q][el_idx[0]];
          best_fit_q   <= el_fit[0];
          st_q         <= GA_IDLE;
        end
        GA_ELITE: if (idx_q == CNT_W'(ELITE - 1)) begin
          idx_q <= CNT_W'(ELITE); sel_b_q <= 1'b0; st_q <= GA_PREP;
        end else idx_q <= idx_q + 1'b1;
        GA_PREP: begin
          thr_q <= thr_d; cum_q <= '0; sidx_q <= '0; st_q <= GA_SCAN;
        end
        GA_SCAN: if (hit) begin
          if (!sel_b_q) begin
            par_a_q <= sidx_q; sel_b_q <= 1'b1; st_q <= GA_PREP;
          end else begin
            par_b_q <= sidx_q; st_q <= GA_WRITE;
          end
        end else begin
          sidx_q <= sidx_q + 1'b1; cum_q <= cum_n;
        end
        GA_WRITE: begin
          sel_b_q <= 1'b0;
          if (32'(idx_q) + 2 >= POP) begin
            bank_q <= ~bank_q; gen_q <= gen_q + 1'b1;
            idx_q <= '0; tot_q <= '0; st_q <= GA_EVAL;
          end else begin
            idx_q <= idx_q + CNT_W'(2); st_q <= GA_PREP;
          end
        end
        default: st_q <= GA_IDLE;
      endcase
    end
  end

  assign eval_req_o   = (st_q == GA_EVAL);
  assign eval_chrom_o = pop_q[bank_q][idx_lo];
  assign busy_o       = (st_q != GA_IDLE);
  assign done_o       = done_q;
  assign best_chrom_o = best_chrom_q;
  assign best_fit_o   = best_fit_q;
endmodule

// File: rtl/ga_engine_chk.sv
module ga_engine_chk #(
  parameter int CHROM_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               eval_req_o,
  input logic               eval_ack_i,
  input logic [CHROM_W-1:0] eval_chrom_o,
  input logic               busy_o,
  input logic               done_o
);
  p_idle_no_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !eval_req_o);

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_req_o && !eval_ack_i) |=> eval_req_o);

  p_chrom_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_req_o && !eval_ack_i) |=> $stable(eval_chrom_o));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind ga_engine ga_engine_chk #(.CHROM_W(CHROM_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .eval_req_o, .eval_ack_i,
  .eval_chrom_o, .busy_o, .done_o
);

// File: tb/tb_ga_engine.sv
module tb_ga_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // default instance
  logic        st0 = 0, req0, ack0 = 0, busy0, done0;
  logic [31:0] seed0 = 0;
  logic [7:0]  gens0 = 0;
  logic [15:0] ch0, fit0 = 0, bch0, bfit0;
  // small instance, no mutation
  logic        st1 = 0, req1, ack1 = 0, busy1, done1;
  logic [31:0] seed1 = 0;
  logic [7:0]  gens1 = 0;
  logic [15:0] ch1, fit1 = 0, bch1, bfit1;

  ga_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st0), .seed_i(seed0), .gens_i(gens0),
    .eval_req_o(req0), .eval_chrom_o(ch0), .eval_ack_i(ack0), .eval_fit_i(fit0),
    .busy_o(busy0), .done_o(done0), .best_chrom_o(bch0), .best_fit_o(bfit0));

  ga_engine #(.POP(8), .MUT_RATE(0)) dut_nm (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st1), .seed_i(seed1), .gens_i(gens1),
    .eval_req_o(req1), .eval_chrom_o(ch1), .eval_ack_i(ack1), .eval_fit_i(fit1),
    .busy_o(busy1), .done_o(done1), .best_chrom_o(bch1), .best_fit_o(bfit1));

  int          mode0 = 0, mode1 = 0, n0 = 0, n1 = 0;
  logic [15:0] rec0 [256];
  logic [15:0] rec1 [64];
  logic [15:0] fr0  [256];

  function automatic logic [15:0] fitf(int mode, int n, logic [15:0] c);
    case (mode)
      0: return c;
      2: return (n == 3) ? 16'd1000 : 16'd0;
      3: return (n == 3 || n == 5) ? 16'd500 : 16'd0;
      default: return 16'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (ack0) ack0 = 1'b0;
    else if (req0 && n0 < 256) begin
      rec0[n0] = ch0; fit0 = fitf(mode0, n0, ch0); fr0[n0] = fit0; n0++; ack0 = 1'b1;
    end
    if (ack1) ack1 = 1'b0;
    else if (req1 && n1 < 64) begin
      rec1[n1] = ch1; fit1 = fitf(mode1, n1, ch1); n1++; ack1 = 1'b1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run0(logic [31:0] s, logic [7:0] g, int m, bit poke);
    n0 = 0; mode0 = m;
    @(negedge clk); seed0 = s; gens0 = g; st0 = 1;
    @(negedge clk); st0 = 0;
    repeat (10) @(negedge clk);
    if (poke) begin st0 = 1; gens0 = 8'd7; @(negedge clk); st0 = 0; end
    while (!done0) @(negedge clk);
  endtask

  task automatic run1(logic [31:0] s, logic [7:0] g, int m);
    n1 = 0; mode1 = m;
    @(negedge clk); seed1 = s; gens1 = g; st1 = 1;
    @(negedge clk); st1 = 0;
    while (!done1) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy0 && !done0 && !req0, "R1", "idle outputs after reset", {busy0, done0, req0}, 0);
    chk(!busy1 && !done1 && !req1, "R1", "idle outputs after reset", {busy1, done1, req1}, 0);
  endtask

  task automatic t_main();
    int bi; logic [15:0] bf;
    run0(32'h1234_5678, 8'd3, 0, 1'b1);
    chk(!busy0, "R4", "busy low with done", busy0, 0);
    chk(n0 == 128, "R3", "evaluation count (R2 start ignored while busy)", n0, 128);
    bi = 96; bf = fr0[96];
    for (int i = 97; i < 128; i++) if (fr0[i] > bf) begin bf = fr0[i]; bi = i; end
    chk(bfit0 == bf, "R4", "best fitness", bfit0, bf);
    chk(bch0 == rec0[bi], "R4", "best chromosome", bch0, rec0[bi]);
    @(negedge clk);
    chk(!done0, "R4", "done one cycle", done0, 0);
    for (int g = 0; g < 3; g++) begin
      int e0 = -1, e1 = -1; logic [15:0] mx = 0, nmx = 0;
      for (int i = 0; i < 32; i++) begin
        int k = g * 32 + i;
        if (e0 < 0 || fr0[k] > fr0[e0]) begin e1 = e0; e0 = k; end
        else if (e1 < 0 || fr0[k] > fr0[e1]) e1 = k;
        if (fr0[k] > mx) mx = fr0[k];
        if (fr0[k+32] > nmx) nmx = fr0[k+32];
      end
      chk(rec0[(g+1)*32] == rec0[e0], "R5", "first elite", rec0[(g+1)*32], rec0[e0]);
      chk(rec0[(g+1)*32+1] == rec0[e1], "R5", "second elite", rec0[(g+1)*32+1], rec0[e1]);
      chk(nmx >= mx, "R5", "best never drops", nmx, mx);
    end
  endtask

  task automatic t_zero_gens();
    run0(32'hCAFE_0001, 8'd0, 0, 1'b0);
    chk(n0 == 32, "R3", "single generation evaluations", n0, 32);
  endtask

  task automatic t_seed();
    logic [15:0] sv [32]; bit same = 1, diff = 0, vary = 0;
    run0(32'h0BAD_F00D, 8'd0, 0, 1'b0);
    for (int i = 0; i < 32; i++) sv[i] = rec0[i];
    run0(32'h0BAD_F00D, 8'd0, 0, 1'b0);
    for (int i = 0; i < 32; i++) if (rec0[i] != sv[i]) same = 0;
    chk(same, "R9", "same seed repeats", same, 1);
    run0(32'h1357_9BDF, 8'd0, 0, 1'b0);
    for (int i = 0; i < 32; i++) if (rec0[i] != sv[i]) diff = 1;
    chk(diff, "R9", "different seed differs", diff, 1);
    run0(32'h0, 8'd0, 0, 1'b0);
    for (int i = 1; i < 32; i++) if (rec0[i] != rec0[0]) vary = 1;
    chk(vary && n0 == 32, "R9", "zero seed still random", vary, 1);
  endtask

  task automatic t_mutation();
    int nm = 0; bit ok = 1;
    run0(32'h5555_AAAA, 8'd1, 2, 1'b0);
    chk(rec0[32] == rec0[3] && rec0[33] == rec0[0], "R5", "elites with single fit", rec0[32], rec0[3]);
    for (int i = 34; i < 64; i++) begin
      int d = $countones(rec0[i] ^ rec0[3]);
      if (d > 1) ok = 0;
      if (d == 1) nm++;
    end
    chk(ok, "R8", "at most one bit flipped", ok, 1);
    chk(nm >= 1 && nm <= 29, "R8", "mutated child count in range", nm, 9);
  endtask

  task automatic t_zero_total();
    bit ok;
    run1(32'h2468_ACE0, 8'd1, 1);
    ok = (rec1[8] == rec1[0]) && (rec1[9] == rec1[1]);
    for (int i = 10; i < 16; i++) if (rec1[i] != rec1[0]) ok = 0;
    chk(ok, "R6", "zero total picks slot 0", rec1[10], rec1[0]);
  endtask

  task automatic t_single();
    bit ok;
    run1(32'h7777_1111, 8'd1, 2);
    ok = (rec1[8] == rec1[3]) && (rec1[9] == rec1[0]);
    for (int i = 10; i < 16; i++) if (rec1[i] != rec1[3]) ok = 0;
    chk(ok, "R6", "only non-zero slot selected (R8 off)", rec1[10], rec1[3]);
  endtask

  task automatic t_xover();
    run1(32'h3141_5926, 8'd1, 3);
    chk(rec1[8] == rec1[3] && rec1[9] == rec1[5], "R5", "tie order of elites", rec1[9], rec1[5]);
    for (int p = 10; p < 16; p += 2) begin
      bit ok = 0;
      for (int xa = 0; xa < 2; xa++)
        for (int yb = 0; yb < 2; yb++)
          for (int c = 1; c < 16; c++) begin
            logic [15:0] x, y, m;
            x = xa ? rec1[5] : rec1[3]; y = yb ? rec1[5] : rec1[3];
            m = 16'hFFFF << c;
            if (rec1[p] == ((x & m) | (y & ~m)) && rec1[p+1] == ((y & m) | (x & ~m))) ok = 1;
          end
      chk(ok, "R7", "child pair is a single-cut mix", rec1[p], rec1[p+1]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_main();
    t_zero_gens();
    t_seed();
    t_mutation();
    t_zero_total();
    t_single();
    t_xover();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule